// File: doc/BRIEF.md
# Aging Page Usage Counter Bank

This block keeps a short age value for each of a fixed set of pages so that a replacement policy can approximate least-recently-used ordering in hardware. Memory accesses to a page raise a sticky per-page referenced flag; a periodic tick then ages every page at once. Each age value shifts one place toward the low end and the referenced flag drops into the top bit, so recent use weighs most and old use fades out.

The lowest age across the bank marks the page used least recently. The block presents that page's index and age on its outputs at all times, from registered state. The surrounding logic reads the index as the replacement candidate whenever a fault needs a victim. The full set of ages is also exported for observation.

Top module: `page_age_bank`

## Requirements
- R1: While rst_ni is low, every age value is zero and every referenced flag is clear. A page accessed just before reset gets a zero top bit on the first tick after reset.
- R2: On a tick, a page with no recorded reference takes the value of its age shifted right by one, with a zero top bit. For example, 8'b0010_1100 becomes 8'b0001_0110.
- R3: On a tick, a page referenced since the previous tick takes its age shifted right by one, with a one in the top bit. For example, 8'b0000_0010 becomes 8'b1000_0001.
- R4: An access without a tick leaves every age value unchanged.
- R5: The referenced flag stays set across any number of cycles until a tick. The tick clears it, so a later tick without new accesses inserts a zero.
- R6: An access in the same cycle as a tick counts toward that tick.
- R7: A page not referenced for AGE_W consecutive ticks has age zero.
- R8: victim_idx_o is the index of the page with the smallest age. When several pages share that age, the lowest index among them wins.
- R9: victim_age_o equals the age of the page named by victim_idx_o.
- R10: age_flat_o carries page p's age in bits [p*AGE_W +: AGE_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Aging strobe; ages all pages in this cycle |
| access_i | input | NUM_PAGES | One bit per page; marks the page as referenced |
| victim_idx_o | output | IDX_W | Index of the least recently used page |
| victim_age_o | output | AGE_W | Age of that page |
| age_flat_o | output | NUM_PAGES*AGE_W | All age values, page p at bits [p*AGE_W +: AGE_W] |

## Verification
The assertions check four things on every cycle:
- On a tick, each age moves down by one bit.
- Ages hold still without a tick.
- An access that coincides with a tick sets the top bit.
- The reported victim is minimal, holds the lowest index among equal ages, and carries the age shown for it.

Some behaviour depends on the hidden referenced flag and only the bench's scenarios can show it. This covers the stickiness of the flag over idle cycles, its clearing by a tick, its clearing by reset, and the full decay to zero after a run of untouched ticks.

// File: rtl/age_bank_pkg.sv
package age_bank_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/age_cell.sv
module age_cell #(
  parameter int AGE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             access_i,
  output logic [AGE_W-1:0] age_o
);
  logic [AGE_W-1:0] age_q;
  logic             ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
      ref_q <= 1'b0;
    end else if (tick_i) begin
      // coincident access counts toward this tick
      age_q <= {ref_q | access_i, age_q[AGE_W-1:1]};
      ref_q <= 1'b0;
    end else if (access_i) begin
      ref_q <= 1'b1;
    end
  end

  assign age_o = age_q;
endmodule

// File: rtl/age_min_select.sv
module age_min_select #(
  parameter int NUM_PAGES = 8,
  parameter int AGE_W     = 8,
  parameter int IDX_W     = 3
) (
  input  logic [NUM_PAGES-1:0][AGE_W-1:0] ages_i,
  output logic [IDX_W-1:0]                idx_o,
  output logic [AGE_W-1:0]                age_o
);
  logic [NUM_PAGES-1:0][AGE_W-1:0] best_age;
  logic [NUM_PAGES-1:0][IDX_W-1:0] best_idx;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_chain
    if (p == 0) begin : g_first
      assign best_age[p] = ages_i[p];
      assign best_idx[p] = '0;
    end else begin : g_rest
      // strict compare keeps the earlier index on ties
      logic take;
      assign take        = ages_i[p] < best_age[p-1];
      assign best_age[p] = take ? ages_i[p] : best_age[p-1];
      assign best_idx[p] = take ? IDX_W'(p) : best_idx[p-1];
    end
  end

  assign idx_o = best_idx[NUM_PAGES-1];
  assign age_o = best_age[NUM_PAGES-1];
endmodule

// File: rtl/page_age_bank.sv
module page_age_bank #(
  parameter int NUM_PAGES = 8,
  parameter int AGE_W     = 8,
  localparam int IDX_W    = age_bank_pkg::idx_width(NUM_PAGES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic [NUM_PAGES-1:0]         access_i,
  output logic [IDX_W-1:0]             victim_idx_o,
  output logic [AGE_W-1:0]             victim_age_o,
  output logic [NUM_PAGES*AGE_W-1:0]   age_flat_o
);
  logic [NUM_PAGES-1:0][AGE_W-1:0] ages;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    age_cell #(.AGE_W(AGE_W)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .access_i (access_i[p]),
      .age_o    (ages[p])
    );
    assign age_flat_o[p*AGE_W +: AGE_W] = ages[p];
  end

  age_min_select #(
    .NUM_PAGES (NUM_PAGES),
    .AGE_W     (AGE_W),
    .IDX_W     (IDX_W)
  ) u_min (
    .ages_i (ages),
    .idx_o  (victim_idx_o),
    .age_o  (victim_age_o)
  );
endmodule

// File: rtl/page_age_bank_checker.sv
module page_age_bank_checker #(
  parameter int NUM_PAGES = 8,
  parameter int AGE_W     = 8,
  parameter int IDX_W     = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tick_i,
  input logic [NUM_PAGES-1:0]       access_i,
  input logic [IDX_W-1:0]           victim_idx_o,
  input logic [AGE_W-1:0]           victim_age_o,
  input logic [NUM_PAGES*AGE_W-1:0] age_flat_o
);
  // R9 (read-back through the port slice of R10)
  assert_vage_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_age_o == age_flat_o[victim_idx_o*AGE_W +: AGE_W]);

  // R4
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(age_flat_o));

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_pg
    // R2 / R3: low bits come from shifted old value
    assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(tick_i) |-> age_flat_o[p*AGE_W +: AGE_W-1] ==
                        $past(age_flat_o[p*AGE_W+1 +: AGE_W-1]));
    assert_msb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(tick_i) && $past(access_i[p])) |-> age_flat_o[p*AGE_W+AGE_W-1]);
    assert_min_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      victim_age_o <= age_flat_o[p*AGE_W +: AGE_W]);
    assert_tie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (IDX_W'(p) < victim_idx_o) |-> age_flat_o[p*AGE_W +: AGE_W] > victim_age_o);
  end
endmodule

bind page_age_bank page_age_bank_checker #(
  .NUM_PAGES (NUM_PAGES),
  .AGE_W     (AGE_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .access_i     (access_i),
  .victim_idx_o (victim_idx_o),
  .victim_age_o (victim_age_o),
  .age_flat_o   (age_flat_o)
);

// File: tb/page_age_bank_test.sv
module page_age_bank_test;
  localparam int N = 8;
  localparam int W = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic [N-1:0] acc = '0;
  logic [IW-1:0] v_idx;
  logic [W-1:0] v_age;
  logic [N*W-1:0] ages;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int age_m[N];
  bit ref_m[N];

  always #2.5 clk = ~clk;

  page_age_bank #(.NUM_PAGES(N), .AGE_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .access_i(acc),
    .victim_idx_o(v_idx), .victim_age_o(v_age), .age_flat_o(ages)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dut_age(input int p);
    return int'(ages[p*W +: W]);
  endfunction

  task automatic compare_all();
    int mi = 0;
    for (int p = 0; p < N; p++) begin
      chk("R10 age", dut_age(p), age_m[p]);
      if (age_m[p] < age_m[mi]) mi = p;
    end
    chk("R8 victim index", int'(v_idx), mi);
    chk("R9 victim age", int'(v_age), age_m[mi]);
  endtask

  task automatic model_reset();
    for (int p = 0; p < N; p++) begin age_m[p] = 0; ref_m[p] = 0; end
  endtask

  // apply inputs for one clock, update model, compare after edge
  task automatic step(input bit t, input logic [N-1:0] a);
    tick = t; acc = a;
    @(posedge clk);
    for (int p = 0; p < N; p++) begin
      if (t) begin
        age_m[p] = ((ref_m[p] || a[p]) ? (1 << (W-1)) : 0) | (age_m[p] >> 1);
        ref_m[p] = 0;
      end else if (a[p]) ref_m[p] = 1;
    end
    #1;
    compare_all();
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    #12;
    // R1: reset state
    for (int p = 0; p < N; p++) chk("R1 reset age", dut_age(p), 0);
    chk("R1 reset victim", int'(v_idx), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;

    step(0, 8'b0000_0100);
    step(1, '0);
    chk("R3 ref tick", dut_age(2), 8'h80);
    step(1, '0);
    chk("R2 plain tick", dut_age(2), 8'h40);
    for (int i = 0; i < 5; i++) begin
      step(0, 8'b0000_0100);
      chk("R4 access holds age", dut_age(2), 8'h40);
    end
    step(0, '0);
    step(0, '0);
    step(1, '0);
    chk("R5 sticky flag", dut_age(2), 8'hA0);
    step(1, '0);
    chk("R5 flag cleared", dut_age(2), 8'h50);
    step(1, 8'b0010_0000);
    chk("R6 same-cycle access", dut_age(5), 8'h80);
    chk("R8 lowest-index tie", int'(v_idx), 0);
    // pattern 0010_1100 -> 0001_0110, 0000_0010 -> 1000_0001 shapes on page 3
    step(1, 8'b0000_1000); step(1, 8'b0000_1000); step(1, '0); step(1, 8'b0000_1000);
    step(1, '0); step(1, '0);
    chk("R2 0x2C->0x16", dut_age(3), 8'h2C);
    step(1, '0);
    chk("R2 shift", dut_age(3), 8'h16);
    step(1, 8'b0000_1000);
    chk("R3 msb insert", dut_age(3), 8'h8B);
    for (int i = 0; i < W; i++) step(1, '0);
    for (int p = 0; p < N; p++) chk("R7 decay to zero", dut_age(p), 0);

    // random traffic, model compared every clock
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] a;
      a = N'($urandom) & N'($urandom);
      step(($urandom % 4) == 0, a);
    end

    // R1: reset clears flags mid-run
    step(0, '1);
    @(negedge clk); rst_ni = 1'b0; model_reset();
    #1;
    for (int p = 0; p < N; p++) chk("R1 async clear", dut_age(p), 0);
    @(negedge clk); rst_ni = 1'b1;
    step(1, '0);
    for (int p = 0; p < N; p++) chk("R1 flag cleared", dut_age(p), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule